// File: doc/BRIEF.md
# ISA Plug-and-Play Card Configuration Controller

This block is the card-level control logic of an ISA plug-and-play card. It watches ISA I/O write cycles aimed at two fixed ports: a register-select port at 0x0279 and a write-data port at 0x0A79. It answers read cycles on a read-data port whose address software can move. While the card waits for the initiation key, the block compares the bytes written to the select port against a 32-byte LFSR sequence. After a complete key the card enters the sleep state. From sleep, wake commands, card-select-number assignment and configuration-control commands move it among sleep, isolation and configuration.

The block holds the card select number, the logical device number, the register pointer and the read-data port address. The serial-isolation bit logic sits outside the block, and so do the EEPROM reader and the logical-device configuration registers. Each of them connects through a one-cycle pulse and a plain data input. A wake into configuration requests a resource-data fetch that starts at EEPROM word 0x0E. Software then pulls resource bytes through a ready flag and a data register.

Top module: `pnp_card_ctrl`

## Requirements
- R1: When reset is released, the card state is wait-for-key (card_state encoding: 0 wait-for-key, 1 sleep, 2 isolation, 3 configuration), csn and ldn are 0, the read-data port is disabled and isa_rdata_oe is low.
- R2: Only in wait-for-key, 32 consecutive writes to I/O 0x0279 equal to the key sequence move the card to sleep. The sequence starts at 0x6A, and each next byte is {b0 xor b1, b7..b1} of the previous byte. In any other state, key bytes have no effect on the state.
- R3: A key byte that does not match restarts the comparison. If that byte equals 0x6A, it counts as the first byte of a new key.
- R4: Outside wait-for-key, a write to 0x0279 selects the register pointer. The pointer stays in force for any number of following data-port writes and read-port reads. In wait-for-key, writes to 0x0A79 are ignored.
- R5: A write to register 0x00 sets the read-data port to I/O address {6'b0, byte, 2'b11}, but only in isolation. A port byte of 0 means the port is disabled.
- R6: The block drives isa_rdata (isa_rdata_oe high) only while isa_addr equals the read-data port, ior_n and aen are both low, and the state is isolation or configuration.
- R7: A write to register 0x03 (wake) whose data equals csn moves the card to isolation when the data is 0, or to configuration when the data is nonzero. In both cases it pulses iso_ptr_rst. If the data differs from csn, the card moves to sleep.
- R8: A wake into configuration pulses ee_fetch once while card_state is configuration. ee_word holds the start word 0x0E.
- R9: Register 0x02 holds self-clearing commands and reads back 0. Bit 2 clears csn and the read-data port. Bit 1 returns the card to wait-for-key and keeps csn and ldn. Bit 0 pulses ld_defaults and keeps csn and the state.
- R10: Register 0x06 (csn) can be read and written in isolation and configuration. A write to it in isolation moves the card to configuration. Register 0x07 (ldn) can be read in both states and written only in configuration.
- R11: Register 0x05 reads {7'b0, res_valid}. Register 0x04 reads res_byte. In configuration, the end of a 0x04 read while res_valid is high pulses res_take exactly once.
- R12: Register 0x01 reads iso_byte, and the end of that read pulses iso_rd in isolation. Registers that are not implemented read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| isa_addr | input | 16 | ISA I/O address |
| isa_wdata | input | 8 | ISA write data |
| iow_n | input | 1 | ISA I/O write strobe, active low |
| ior_n | input | 1 | ISA I/O read strobe, active low |
| aen | input | 1 | ISA address enable (DMA cycle), blocks decoding when high |
| isa_rdata | output | 8 | Read-data port value |
| isa_rdata_oe | output | 1 | Read-data bus drive enable |
| iso_byte | input | 8 | Value returned by the external isolation logic |
| iso_rd | output | 1 | Pulse: an isolation read completed |
| iso_ptr_rst | output | 1 | Pulse: reset the serial-identifier pointer |
| res_byte | input | 8 | Next resource-data byte |
| res_valid | input | 1 | Resource byte ready |
| res_take | output | 1 | Pulse: resource byte consumed |
| ee_fetch | output | 1 | Pulse: start a resource fetch |
| ee_word | output | 8 | EEPROM start word of the fetch |
| ld_defaults | output | 1 | Pulse: restore logical-device defaults |
| card_state | output | 2 | Card state |
| csn | output | 8 | Card select number |
| ldn | output | 8 | Logical device number |

## Verification
The assertions check on every cycle that sleep is reached from wait-for-key only after a completed key, and that the key counter clears whenever the card leaves wait-for-key. They also check that the read-data port and ldn change only in the states allowed to change them, that fetch and pointer-reset pulses appear only in the states they lead to, and that each consumption pulse lasts one cycle. Only the bench's scenarios can show the rest: the exact key sequence and its restart rules, the port decode across many port bytes, wake matching against csn, the effect of each command bit, and that state survives ignored writes.

// File: rtl/pnp_pkg.sv
// Shared definitions for the plug-and-play card controller.
// Assumes: 8-bit register indices and an 8-bit key LFSR.
package pnp_pkg;
    typedef enum logic [1:0] {
        ST_WFK    = 2'd0,
        ST_SLEEP  = 2'd1,
        ST_ISOL   = 2'd2,
        ST_CONFIG = 2'd3
    } card_st_t;

    localparam logic [7:0] REG_RDPORT = 8'h00;
    localparam logic [7:0] REG_ISOL   = 8'h01;
    localparam logic [7:0] REG_CMD    = 8'h02;
    localparam logic [7:0] REG_WAKE   = 8'h03;
    localparam logic [7:0] REG_RES    = 8'h04;
    localparam logic [7:0] REG_STAT   = 8'h05;
    localparam logic [7:0] REG_CSN    = 8'h06;
    localparam logic [7:0] REG_LDN    = 8'h07;

    // One step of the key LFSR: shift right, feedback of bits 0 and 1 into bit 7.
    function automatic logic [7:0] key_step(input logic [7:0] v);
        return {v[1] ^ v[0], v[7:1]};
    endfunction
endpackage

// File: rtl/pnp_bus_port.sv
// ISA I/O cycle front end. Turns the falling edge of the write strobe into
// one-cycle write events for the select port and the write-data port, flags a
// live hit on the read-data port and marks the end of each read that hit.
// Assumes: address and data are stable before a strobe falls; strobes last
// at least two clocks.
module pnp_bus_port #(
    parameter int          ADDR_W     = 16,
    parameter logic [15:0] SEL_PORT   = 16'h0279,
    parameter logic [15:0] WDATA_PORT = 16'h0A79
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] isa_addr,
    input  logic [7:0]        isa_wdata,
    input  logic              iow_n,
    input  logic              ior_n,
    input  logic              aen,
    input  logic [7:0]        rd_port,
    input  logic              rd_en,
    output logic              sel_wr,
    output logic              data_wr,
    output logic [7:0]        wr_byte,
    output logic              rd_hit,
    output logic              rd_done
);
    localparam int HI_W = ADDR_W - 10;

    logic iow_q, ior_q, hit_q;
    logic wr_fall;

    // Write strobe falls while the address is an I/O (non-DMA) cycle.
    assign wr_fall = iow_q & ~iow_n & ~aen;

    // Read port decode: {zeros, port byte, 2'b11}, port byte 0 means disabled.
    assign rd_hit = rd_en && (rd_port != 8'd0) && !ior_n && !aen &&
                    (isa_addr == {{HI_W{1'b0}}, rd_port, 2'b11});

    // Strobe history, write events and read-completion marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iow_q   <= 1'b1;
            ior_q   <= 1'b1;
            hit_q   <= 1'b0;
            sel_wr  <= 1'b0;
            data_wr <= 1'b0;
            wr_byte <= 8'd0;
            rd_done <= 1'b0;
        end else begin
            iow_q   <= iow_n;
            ior_q   <= ior_n;
            hit_q   <= rd_hit;
            sel_wr  <= wr_fall && (isa_addr == ADDR_W'(SEL_PORT));
            data_wr <= wr_fall && (isa_addr == ADDR_W'(WDATA_PORT));
            if (wr_fall) wr_byte <= isa_wdata;
            rd_done <= hit_q && ior_n && !ior_q;
        end
    end
endmodule

// File: rtl/pnp_key_match.sv
// Initiation key comparator. Follows the key LFSR byte by byte while enabled
// and pulses key_done after KEY_LEN consecutive matching writes.
// Assumes: en is high only in wait-for-key; a mismatching byte equal to the
// seed starts a new attempt at position 1.
module pnp_key_match #(
    parameter int         KEY_LEN = 32,
    parameter logic [7:0] SEED    = 8'h6A
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       stb,
    input  logic [7:0] byte_in,
    output logic       key_done
);
    import pnp_pkg::*;

    localparam int IDX_W = (KEY_LEN > 2) ? $clog2(KEY_LEN) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(KEY_LEN - 1);

    logic [IDX_W-1:0] idx;
    logic [7:0]       want;

    // Position tracking and expected-byte generation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx      <= '0;
            want     <= SEED;
            key_done <= 1'b0;
        end else begin
            key_done <= 1'b0;
            if (!en) begin
                idx  <= '0;
                want <= SEED;
            end else if (stb) begin
                if (byte_in == want) begin
                    if (idx == LAST) begin
                        key_done <= 1'b1;
                        idx      <= '0;
                        want     <= SEED;
                    end else begin
                        idx  <= idx + 1'b1;
                        want <= key_step(want);
                    end
                end else if (byte_in == SEED) begin
                    idx  <= IDX_W'(1);
                    want <= key_step(SEED);
                end else begin
                    idx  <= '0;
                    want <= SEED;
                end
            end
        end
    end

    assert_key_after_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        key_done |-> $past(stb && en));
    assert_key_cleared_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (idx == '0 && want == SEED));
endmodule

// File: rtl/pnp_read_mux.sv
// Read-data selection for the register the pointer addresses.
// Assumes: the caller gates the result with the port hit.
module pnp_read_mux (
    input  logic [7:0] ptr,
    input  logic [7:0] csn,
    input  logic [7:0] ldn,
    input  logic [7:0] iso_byte,
    input  logic [7:0] res_byte,
    input  logic       res_valid,
    output logic [7:0] rdata
);
    import pnp_pkg::*;

    // Register readback; write-only and unimplemented registers give 0.
    always_comb begin
        case (ptr)
            REG_ISOL: rdata = iso_byte;
            REG_RES:  rdata = res_byte;
            REG_STAT: rdata = {7'd0, res_valid};
            REG_CSN:  rdata = csn;
            REG_LDN:  rdata = ldn;
            default:  rdata = 8'd0;
        endcase
    end
endmodule

// File: rtl/pnp_card_ctrl.sv
// Card-level plug-and-play configuration controller. Tracks the card state,
// holds csn, ldn, register pointer and read-port byte, executes the wake and
// configuration-control commands and emits one-cycle requests to the external
// isolation, EEPROM and logical-device logic.
// Assumes: ISA strobes are synchronous to clk; external logic handles the
// serial identifier and the resource-data fetch.
module pnp_card_ctrl #(
    parameter int         ADDR_W    = 16,
    parameter int         KEY_LEN   = 32,
    parameter logic [7:0] KEY_SEED  = 8'h6A,
    parameter logic [7:0] RES_START = 8'h0E
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] isa_addr,
    input  logic [7:0]        isa_wdata,
    input  logic              iow_n,
    input  logic              ior_n,
    input  logic              aen,
    output logic [7:0]        isa_rdata,
    output logic              isa_rdata_oe,
    input  logic [7:0]        iso_byte,
    output logic              iso_rd,
    output logic              iso_ptr_rst,
    input  logic [7:0]        res_byte,
    input  logic              res_valid,
    output logic              res_take,
    output logic              ee_fetch,
    output logic [7:0]        ee_word,
    output logic              ld_defaults,
    output logic [1:0]        card_state,
    output logic [7:0]        csn,
    output logic [7:0]        ldn
);
    import pnp_pkg::*;

    card_st_t   st;
    logic [7:0] csn_q, ldn_q, rdp_q, ptr_q;
    logic       sel_wr, data_wr, rd_hit, rd_done, key_done;
    logic [7:0] wr_byte, mux_data;
    logic       port_live, in_wfk;

    assign in_wfk    = (st == ST_WFK);
    assign port_live = (st == ST_ISOL) || (st == ST_CONFIG);

    pnp_bus_port #(.ADDR_W(ADDR_W)) u_bus (
        .clk(clk), .rst_n(rst_n), .isa_addr(isa_addr), .isa_wdata(isa_wdata),
        .iow_n(iow_n), .ior_n(ior_n), .aen(aen), .rd_port(rdp_q),
        .rd_en(port_live), .sel_wr(sel_wr), .data_wr(data_wr),
        .wr_byte(wr_byte), .rd_hit(rd_hit), .rd_done(rd_done)
    );

    pnp_key_match #(.KEY_LEN(KEY_LEN), .SEED(KEY_SEED)) u_key (
        .clk(clk), .rst_n(rst_n), .en(in_wfk), .stb(sel_wr),
        .byte_in(wr_byte), .key_done(key_done)
    );

    pnp_read_mux u_mux (
        .ptr(ptr_q), .csn(csn_q), .ldn(ldn_q), .iso_byte(iso_byte),
        .res_byte(res_byte), .res_valid(res_valid), .rdata(mux_data)
    );

    // Card state, register file and command side effects.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st          <= ST_WFK;
            csn_q       <= 8'd0;
            ldn_q       <= 8'd0;
            rdp_q       <= 8'd0;
            ptr_q       <= 8'd0;
            iso_rd      <= 1'b0;
            iso_ptr_rst <= 1'b0;
            res_take    <= 1'b0;
            ee_fetch    <= 1'b0;
            ld_defaults <= 1'b0;
        end else begin
            iso_rd      <= 1'b0;
            iso_ptr_rst <= 1'b0;
            res_take    <= 1'b0;
            ee_fetch    <= 1'b0;
            ld_defaults <= 1'b0;

            if (key_done && in_wfk) st <= ST_SLEEP;

            if (sel_wr && !in_wfk) ptr_q <= wr_byte;

            if (data_wr && !in_wfk) begin
                case (ptr_q)
                    REG_RDPORT: if (st == ST_ISOL) rdp_q <= wr_byte;
                    REG_CMD: begin
                        if (wr_byte[2]) begin
                            csn_q <= 8'd0;
                            rdp_q <= 8'd0;
                        end
                        if (wr_byte[1]) st <= ST_WFK;
                        if (wr_byte[0]) ld_defaults <= 1'b1;
                    end
                    REG_WAKE: begin
                        if (wr_byte == csn_q) begin
                            iso_ptr_rst <= 1'b1;
                            if (wr_byte == 8'd0) begin
                                st <= ST_ISOL;
                            end else begin
                                st       <= ST_CONFIG;
                                ee_fetch <= 1'b1;
                            end
                        end else begin
                            st <= ST_SLEEP;
                        end
                    end
                    REG_CSN: if (port_live) begin
                        csn_q <= wr_byte;
                        if (st == ST_ISOL) st <= ST_CONFIG;
                    end
                    REG_LDN: if (st == ST_CONFIG) ldn_q <= wr_byte;
                    default: ;
                endcase
            end

            if (rd_done) begin
                if (ptr_q == REG_ISOL && st == ST_ISOL) iso_rd <= 1'b1;
                if (ptr_q == REG_RES && st == ST_CONFIG && res_valid) res_take <= 1'b1;
            end
        end
    end

    assign isa_rdata    = rd_hit ? mux_data : 8'd0;
    assign isa_rdata_oe = rd_hit;
    assign ee_word      = RES_START;
    assign card_state   = st;
    assign csn          = csn_q;
    assign ldn          = ldn_q;

    assert_sleep_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SLEEP && $past(st) == ST_WFK) |-> $past(key_done));
    assert_port_change_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rdp_q != $past(rdp_q)) |-> ($past(st) == ST_ISOL || rdp_q == 8'd0));
    assert_ptr_reset_state_R7: assert property (@(posedge clk) disable iff (!rst_n)
        iso_ptr_rst |-> (st == ST_ISOL || st == ST_CONFIG));
    assert_fetch_in_config_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ee_fetch |-> (st == ST_CONFIG));
    assert_ldn_change_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (ldn_q != $past(ldn_q)) |-> ($past(st) == ST_CONFIG));
    assert_take_single_R11: assert property (@(posedge clk) disable iff (!rst_n)
        res_take |=> !res_take);
endmodule

// File: tb/sim_pnp_card_ctrl.sv
module sim_pnp_card_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] isa_addr = 16'd0;
    logic [7:0]  isa_wdata = 8'd0;
    logic        iow_n = 1'b1, ior_n = 1'b1, aen = 1'b0;
    logic [7:0]  isa_rdata;
    logic        isa_rdata_oe;
    logic [7:0]  iso_byte = 8'h00;
    logic        iso_rd, iso_ptr_rst, res_take, ee_fetch, ld_defaults;
    logic [7:0]  res_byte = 8'h00;
    logic        res_valid = 1'b0;
    logic [7:0]  ee_word, csn, ldn;
    logic [1:0]  card_state;

    int checks = 0, errors = 0;
    int n_iso_rd = 0, n_ptr_rst = 0, n_take = 0, n_fetch = 0, n_def = 0;
    logic [7:0] d;
    logic       oe;

    always #5 clk = ~clk;

    pnp_card_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .isa_addr(isa_addr), .isa_wdata(isa_wdata),
        .iow_n(iow_n), .ior_n(ior_n), .aen(aen), .isa_rdata(isa_rdata),
        .isa_rdata_oe(isa_rdata_oe), .iso_byte(iso_byte), .iso_rd(iso_rd),
        .iso_ptr_rst(iso_ptr_rst), .res_byte(res_byte), .res_valid(res_valid),
        .res_take(res_take), .ee_fetch(ee_fetch), .ee_word(ee_word),
        .ld_defaults(ld_defaults), .card_state(card_state), .csn(csn), .ldn(ldn)
    );

    always @(posedge clk) begin
        if (iso_rd)      n_iso_rd++;
        if (iso_ptr_rst) n_ptr_rst++;
        if (res_take)    n_take++;
        if (ee_fetch)    n_fetch++;
        if (ld_defaults) n_def++;
    end

    function automatic logic [7:0] nxt(input logic [7:0] v);
        return {v[0] ^ v[1], v[7:1]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] v);
        @(negedge clk);
        isa_addr = a; isa_wdata = v; iow_n = 1'b0;
        repeat (3) @(negedge clk);
        iow_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic rd(input logic [15:0] a, output logic [7:0] v, output logic e);
        @(negedge clk);
        isa_addr = a; ior_n = 1'b0;
        repeat (2) @(negedge clk);
        v = isa_rdata; e = isa_rdata_oe;
        ior_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic wr_reg(input logic [7:0] r, input logic [7:0] v);
        wr(16'h0279, r);
        wr(16'h0A79, v);
    endtask

    task automatic rd_reg(input logic [15:0] port, input logic [7:0] r,
                          output logic [7:0] v, output logic e);
        wr(16'h0279, r);
        rd(port, v, e);
    endtask

    task automatic send_key(input int first, input int last);
        logic [7:0] b = 8'h6A;
        for (int i = 0; i < 32; i++) begin
            if (i >= first && i <= last) wr(16'h0279, b);
            b = nxt(b);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        // R1 reset state
        check("R1 state", card_state, 0);
        check("R1 csn", csn, 0);
        check("R1 ldn", ldn, 0);
        rd(16'h0203, d, oe);
        check("R1 no drive", oe, 0);

        // R2/R3 broken keys: a foreign byte at positions 1, 16, 31
        for (int k = 1; k < 32; k += 15) begin
            send_key(0, k - 1);
            wr(16'h0279, 8'h00);
            send_key(k, 31);
            check("R3 broken key stays wfk", card_state, 0);
        end
        // R3 seed byte inside a partial key restarts at position 1
        send_key(0, 9);
        send_key(0, 31);
        check("R3 seed restart reaches sleep", card_state, 1);
        // R2 key again outside wait-for-key has no effect
        send_key(0, 31);
        check("R2 key ignored in sleep", card_state, 1);

        // R7 wake with 0 matches csn 0 -> isolation
        wr_reg(8'h03, 8'h00);
        check("R7 wake0 to isolation", card_state, 2);
        check("R7 ptr reset pulse", n_ptr_rst, 1);

        // R5/R6/R12 sweep of read-port bytes
        for (int p = 8'h80; p <= 8'hFF; p += 9) begin
            logic [15:0] pa;
            pa = {6'd0, 8'(p), 2'b11};
            iso_byte = 8'(p) ^ 8'h5A;
            wr_reg(8'h00, 8'(p));
            rd_reg(pa, 8'h01, d, oe);
            check("R12 iso read data", d, 8'(p) ^ 8'h5A);
            check("R5 port decode", oe, 1);
            rd(pa ^ 16'h0004, d, oe);
            check("R6 other address idle", oe, 0);
        end
        check("R12 iso_rd pulses", n_iso_rd, 15);
        wr_reg(8'h00, 8'h80);
        aen = 1'b1;
        rd(16'h0203, d, oe);
        aen = 1'b0;
        check("R6 aen blocks drive", oe, 0);
        rd_reg(16'h0203, 8'h20, d, oe);
        check("R12 unimplemented reads 0", d, 0);
        check("R12 unimplemented drives", oe, 1);

        // R10 csn assignment in isolation -> configuration
        wr_reg(8'h06, 8'h05);
        check("R10 csn write to config", card_state, 3);
        check("R10 csn value", csn, 5);
        // R5 port write ignored in configuration
        wr_reg(8'h00, 8'h90);
        rd_reg(16'h0203, 8'h06, d, oe);
        check("R5 port kept in config", oe, 1);
        check("R10 csn readback", d, 5);
        rd(16'h0203, d, oe);
        check("R4 pointer retained", d, 5);
        wr_reg(8'h07, 8'h03);
        rd_reg(16'h0203, 8'h07, d, oe);
        check("R10 ldn readback", d, 3);

        // R11 resource handshake
        rd_reg(16'h0203, 8'h05, d, oe);
        check("R11 status not ready", d, 0);
        res_valid = 1'b1; res_byte = 8'hA5;
        rd(16'h0203, d, oe);
        check("R11 status ready", d, 1);
        rd_reg(16'h0203, 8'h04, d, oe);
        check("R11 resource byte", d, 8'hA5);
        check("R11 one take", n_take, 1);
        res_valid = 1'b0;
        rd(16'h0203, d, oe);
        check("R11 no take when not ready", n_take, 1);

        // R7 mismatching wake -> sleep, not driven
        wr_reg(8'h03, 8'h02);
        check("R7 mismatch to sleep", card_state, 1);
        rd(16'h0203, d, oe);
        check("R6 no drive in sleep", oe, 0);
        // R8 matching wake -> configuration + fetch
        wr_reg(8'h03, 8'h05);
        check("R7 wake to config", card_state, 3);
        check("R8 fetch pulse", n_fetch, 1);
        check("R8 start word", ee_word, 8'h0E);
        check("R7 ptr reset pulse 2", n_ptr_rst, 2);

        // R9 command bits
        wr_reg(8'h02, 8'h01);
        check("R9 defaults pulse", n_def, 1);
        check("R9 bit0 keeps csn", csn, 5);
        check("R9 bit0 keeps state", card_state, 3);
        rd(16'h0203, d, oe);
        check("R9 command reads 0", d, 0);
        wr(16'h0A79, 8'h02);
        check("R9 bit1 to wfk", card_state, 0);
        check("R9 bit1 keeps csn", csn, 5);
        check("R9 bit1 keeps ldn", ldn, 3);
        wr(16'h0A79, 8'h04);
        check("R4 data write ignored in wfk", csn, 5);
        send_key(0, 31);
        wr_reg(8'h03, 8'h05);
        check("R8 second fetch", n_fetch, 2);
        wr_reg(8'h02, 8'h04);
        check("R9 bit2 clears csn", csn, 0);
        check("R9 bit2 keeps state", card_state, 3);
        rd(16'h0203, d, oe);
        check("R9 bit2 clears port", oe, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule